// File: doc/BRIEF.md
# Address-select reward environment

This block is a self-contained test environment for a hardware rule learner. It presents a pseudo-random problem word of N = K + 2^K bits, in which the top K bits form an address and the low 2^K bits form a data field. The learner answers with a single action bit. The environment scores that answer and returns a reward one cycle later: the full reward when the answer equals the addressed data bit, and nothing otherwise.

A run-time invert input flips the correct answer. This models a sudden change in the environment that the learner has to re-adapt to. Problem words come from a maximal-length 64-bit LFSR. The LFSR advances once per scored answer and can be reseeded. Two saturating counters track the answers given and the answers rewarded. A synchronous clear input resets both counters.

Top module: `mux_reward_env`

## Requirements
- R1: `problem_o` equals the low N bits of the LFSR state, where N = K + 2^K. The address field is bits [N-1:N-K] and the data field is bits [2^K-1:0].
- R2: The correct answer is data-field bit number `addr`, where data bit 0 is the least significant bit of `problem_o`. For K=2, the word 011101 gives 0 and the word 100100 gives 1.
- R3: When `invert_i` is 1 in the cycle of the action, the correct answer is the complement of the addressed bit. For example, 011101 then gives 1.
- R4: Exactly one cycle after a cycle with `action_valid_i`=1, `reward_valid_o` is 1 and `reward_o` is REWARD_MAX (1000) if `action_i` equaled the correct answer, else 0. After a cycle without an action, `reward_valid_o` and `reward_o` are 0.
- R5: The LFSR shifts right in Galois form. If the old bit 0 was 1, the mask 64'hD800000000000000 is XORed into the shifted value. It steps once per cycle with `action_valid_i`=1 and otherwise holds. After reset its state is 1.
- R6: `seed_load_i` loads `seed_i` into the LFSR, and a zero seed loads 1 instead. The load takes priority over a step in the same cycle. An action in that cycle is still scored against the old problem.
- R7: After reset both counters are 0. `step_cnt_o` rises by one per action, and `correct_cnt_o` rises by one per rewarded action.
- R8: `clear_i` sets both counters to 0. An action in the same cycle is still counted, so the step counter becomes 1 and the correct counter becomes 1 if that action was rewarded, else 0.
- R9: Both counters saturate at 2^CNT_W-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of both counters |
| invert_i | input | 1 | Complement the correct answer |
| seed_load_i | input | 1 | Load `seed_i` into the LFSR |
| seed_i | input | LFSR_W | LFSR seed value |
| problem_o | output | N | Current problem word |
| action_valid_i | input | 1 | Learner presents an action this cycle |
| action_i | input | 1 | Learner's action bit |
| reward_valid_o | output | 1 | Reward for the previous cycle's action |
| reward_o | output | RWD_W | Reward value, REWARD_MAX or 0 |
| step_cnt_o | output | CNT_W | Actions seen since clear |
| correct_cnt_o | output | CNT_W | Rewarded actions since clear |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a counter clear together with a scored action. This is provoked both at random and directly, with the counters saturated and an answer known to be wrong. The result is judged by requiring a step count of exactly 1 and a correct count of 0 on the next cycle.

The second pair is a reseed together with an action. The bench expects the reward to reflect the old problem while the next problem is the loaded seed. A behavioural model runs in step with the design and compares every output on every clock.

// File: rtl/mux_env_pkg.sv
package mux_env_pkg;
  localparam int unsigned MUX_REWARD_MAX = 1000;

  typedef enum logic [1:0] {
    LF_HOLD = 2'd0,
    LF_STEP = 2'd1,
    LF_LOAD = 2'd2
  } lfsr_op_e;

  function automatic int unsigned mux_len(input int unsigned k);
    return k + (32'd1 << k);
  endfunction
endpackage

// File: rtl/mux_lfsr.sv
module mux_lfsr
  import mux_env_pkg::*;
#(
  parameter int unsigned W        = 64,
  parameter logic [W-1:0] TAPS    = 64'hD800000000000000,
  parameter logic [W-1:0] RST_SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lfsr_op_e     op_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    unique case (op_i)
      LF_LOAD: state_d = (seed_i == '0) ? W'(1) : seed_i;
      LF_STEP: state_d = {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RST_SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: a maximal-length sequence never reaches the all-zero lockup state
  a_r5_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0);
  // R5: no step and no load leaves the state untouched
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == LF_HOLD |=> $stable(state_o));
  // R6: load of a nonzero seed lands unchanged
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == LF_LOAD && seed_i != '0) |=> state_o == $past(seed_i));
endmodule

// File: rtl/mux_oracle.sv
module mux_oracle #(
  parameter int unsigned K = 3,
  parameter int unsigned N = K + (1 << K)
) (
  input  logic [N-1:0] problem_i,
  input  logic         invert_i,
  output logic         answer_o
);
  localparam int unsigned D = 1 << K;

  logic [K-1:0] addr;
  logic [D-1:0] data;

  assign addr     = problem_i[N-1 -: K];
  assign data     = problem_i[D-1:0];
  assign answer_o = data[addr] ^ invert_i;
endmodule

// File: rtl/mux_sat_counter.sv
module mux_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clear_i)               cnt_q <= {{(W-1){1'b0}}, inc_i};
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r7_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && inc_i && cnt_o != MAX) |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r7_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !inc_i) |=> $stable(cnt_o));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_o <= W'(1));
  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_o == MAX) |=> cnt_o == MAX);
endmodule

// File: rtl/mux_reward_env.sv
module mux_reward_env
  import mux_env_pkg::*;
#(
  parameter int unsigned K          = 3,
  parameter int unsigned LFSR_W     = 64,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 64'hD800000000000000,
  parameter logic [LFSR_W-1:0] RST_SEED  = 1,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned REWARD_MAX = MUX_REWARD_MAX,
  localparam int unsigned N         = mux_len(K),
  localparam int unsigned RWD_W     = $clog2(REWARD_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              invert_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [N-1:0]      problem_o,
  input  logic              action_valid_i,
  input  logic              action_i,
  output logic              reward_valid_o,
  output logic [RWD_W-1:0]  reward_o,
  output logic [CNT_W-1:0]  step_cnt_o,
  output logic [CNT_W-1:0]  correct_cnt_o
);
  localparam logic [RWD_W-1:0] RWD_FULL = RWD_W'(REWARD_MAX);

  lfsr_op_e          lf_op;
  logic [LFSR_W-1:0] lf_state;
  logic              answer;
  logic              hit;
  logic              rv_q;
  logic [RWD_W-1:0]  rw_q;

  // load wins over step; action is still scored on the current word
  assign lf_op = seed_load_i    ? LF_LOAD :
                 action_valid_i ? LF_STEP : LF_HOLD;

  mux_lfsr #(
    .W       (LFSR_W),
    .TAPS    (LFSR_TAPS),
    .RST_SEED(RST_SEED)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (lf_op),
    .seed_i (seed_i),
    .state_o(lf_state)
  );

  assign problem_o = lf_state[N-1:0];

  mux_oracle #(.K(K), .N(N)) u_oracle (
    .problem_i(problem_o),
    .invert_i (invert_i),
    .answer_o (answer)
  );

  assign hit = action_valid_i && (action_i == answer);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q <= 1'b0;
      rw_q <= '0;
    end else begin
      rv_q <= action_valid_i;
      rw_q <= hit ? RWD_FULL : '0;
    end
  end

  assign reward_valid_o = rv_q;
  assign reward_o       = rw_q;

  mux_sat_counter #(.W(CNT_W)) u_step_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .inc_i  (action_valid_i),
    .cnt_o  (step_cnt_o)
  );

  mux_sat_counter #(.W(CNT_W)) u_correct_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .inc_i  (hit),
    .cnt_o  (correct_cnt_o)
  );

  a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_valid_i |=> reward_valid_o);
  a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !action_valid_i |=> (!reward_valid_o && reward_o == '0));
  a_r4_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reward_valid_o |-> (reward_o == RWD_FULL || reward_o == '0));
  a_r7_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    correct_cnt_o <= step_cnt_o);
  a_r6_reseed_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_load_i && seed_i == '0) |=> problem_o == N'(1));
endmodule

// File: tb/sim_mux_reward_env.sv
`timescale 1ns/1ps
module sim_mux_reward_env;
  localparam int unsigned K     = 2;
  localparam int unsigned N     = K + (1 << K);
  localparam int unsigned LW    = 64;
  localparam int unsigned CW    = 8;
  localparam int unsigned CMAX  = (1 << CW) - 1;
  localparam int unsigned RMAX  = 1000;
  localparam logic [63:0] MASK  = 64'hD800000000000000;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          clear_i, invert_i, seed_load_i, action_valid_i, action_i;
  logic [LW-1:0] seed_i;
  logic [N-1:0]  problem_o;
  logic          reward_valid_o;
  logic [9:0]    reward_o;
  logic [CW-1:0] step_cnt_o, correct_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] m_lfsr;
  int          m_step, m_corr, m_rw;
  logic        m_rv;

  always #4 clk_i = ~clk_i;

  mux_reward_env #(.K(K), .CNT_W(CW)) u0 (
    .clk_i, .rst_ni, .clear_i, .invert_i, .seed_load_i, .seed_i,
    .problem_o, .action_valid_i, .action_i, .reward_valid_o, .reward_o,
    .step_cnt_o, .correct_cnt_o
  );

  function automatic logic ref_ans(input longint unsigned prob, input logic inv);
    longint unsigned a = prob >> (1 << K);
    longint unsigned b = (prob >> a) & 1;
    return b[0] ^ inv;
  endfunction

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string rtag, input string ctag);
    chk("R1", "problem", longint'(problem_o), longint'(m_lfsr[N-1:0]));
    chk("R4", "reward_valid", longint'(reward_valid_o), longint'(m_rv));
    chk(rtag, "reward", longint'(reward_o), longint'(m_rw));
    chk(ctag, "step_cnt", longint'(step_cnt_o), longint'(m_step));
    chk(ctag, "correct_cnt", longint'(correct_cnt_o), longint'(m_corr));
  endtask

  task automatic cyc(input logic av, input logic act, input logic inv,
                     input logic clr, input logic ld, input logic [63:0] sd,
                     input string rtag, input string ctag);
    logic hit;
    action_valid_i = av; action_i = act; invert_i = inv;
    clear_i = clr; seed_load_i = ld; seed_i = sd;
    hit = av && (act == ref_ans(longint'(m_lfsr[N-1:0]), inv));
    if (ld)      m_lfsr = (sd == 0) ? 64'd1 : sd;
    else if (av) m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? MASK : 64'd0);
    m_rv = av;
    m_rw = hit ? RMAX : 0;
    if (clr) begin
      m_step = av ? 1 : 0;
      m_corr = hit ? 1 : 0;
    end else begin
      if (av && m_step < CMAX)  m_step++;
      if (hit && m_corr < CMAX) m_corr++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    cmp_all(rtag, ctag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ans;
    rst_ni = 1'b0; clear_i = 0; invert_i = 0; seed_load_i = 0;
    seed_i = '0; action_valid_i = 0; action_i = 0;
    m_lfsr = 64'd1; m_step = 0; m_corr = 0; m_rw = 0; m_rv = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state: R5 seed 1, R7 counters zero
    cmp_all("R4", "R7");
    chk("R5", "reset problem", longint'(problem_o), 1);

    // R2 worked examples
    cyc(0, 0, 0, 0, 1, 64'h1D, "R4", "R7");
    chk("R1", "loaded 011101", longint'(problem_o), 6'b011101);
    cyc(1, 0, 0, 0, 1, 64'h1D, "R2", "R7");  // R6: load and action together
    chk("R2", "011101 ans 0 reward", longint'(reward_o), RMAX);
    chk("R6", "reload after action", longint'(problem_o), 6'b011101);
    cyc(1, 1, 1, 0, 1, 64'h24, "R3", "R7");
    chk("R3", "011101 inverted ans 1", longint'(reward_o), RMAX);
    cyc(1, 1, 0, 0, 0, 64'h0, "R2", "R7");
    chk("R2", "100100 ans 1 reward", longint'(reward_o), RMAX);
    cyc(0, 0, 0, 0, 1, 64'h1D, "R4", "R7");
    cyc(1, 0, 1, 0, 0, 64'h0, "R3", "R7");
    chk("R3", "011101 inverted, ans 0 no reward", longint'(reward_o), 0);
    // R6 zero seed
    cyc(0, 0, 0, 0, 1, 64'h0, "R4", "R7");
    chk("R6", "zero seed gives 1", longint'(problem_o), 1);
    // R4 idle holds problem, no reward
    cyc(0, 1, 0, 0, 0, 64'h0, "R4", "R7");
    chk("R4", "idle valid", longint'(reward_valid_o), 0);

    // R9 saturation with always-correct answers
    cyc(0, 0, 0, 1, 1, 64'h0123_4567_89AB_CDEF, "R4", "R8");
    for (int i = 0; i < 300; i++) begin
      ans = ref_ans(longint'(m_lfsr[N-1:0]), 1'b0);
      cyc(1, ans, 0, 0, 0, 64'h0, "R2", "R9");
    end
    chk("R9", "step saturated", longint'(step_cnt_o), CMAX);
    chk("R9", "correct saturated", longint'(correct_cnt_o), CMAX);
    // R8 clear together with a wrong action
    ans = ref_ans(longint'(m_lfsr[N-1:0]), 1'b0);
    cyc(1, ~ans, 0, 1, 0, 64'h0, "R4", "R8");
    chk("R8", "step after clear+action", longint'(step_cnt_o), 1);
    chk("R8", "correct after clear+miss", longint'(correct_cnt_o), 0);
    cyc(0, 0, 0, 1, 0, 64'h0, "R4", "R8");
    chk("R8", "step after plain clear", longint'(step_cnt_o), 0);

    // random traffic, model compared every clock
    begin
      logic inv = 1'b0;
      for (int i = 0; i < 3000; i++) begin
        logic [63:0] sd;
        if ($urandom_range(0, 19) == 0) inv = ~inv;
        sd = {$urandom(), $urandom()};
        cyc(($urandom_range(0, 1) == 1), $urandom_range(0, 1), inv,
            ($urandom_range(0, 29) == 0), ($urandom_range(0, 49) == 0), sd,
            inv ? "R3" : "R2", "R7");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule